// File: doc/BRIEF.md
# Auto-Increment Word Program Sequencer

This block sits behind the command decoder of a serial flash device and runs the auto-increment word programming mode. The serial front end passes it three kinds of event: an opcode pulse at the end of the first byte of a chip-select frame, a pulse for each later byte of that frame, and a pulse when the frame closes. The sequencer turns complete, legal frames into single-cycle word program requests. Each request carries an even byte address and a 16-bit word.

The opening command (ADh) is accepted only while the write-enable latch is set. It supplies a start address and two data bytes. Every later ADh frame supplies only two data bytes. The sequencer programs them at the previous address plus two, so it keeps the address across separate frames. A counter stands in for the program engine and reports busy after each request. Two opcodes switch a ready/busy indication on serial-out while the mode is active. A write-disable, or a status read issued while the engine is idle, ends the mode and clears the write-enable latch.

Every command acts when its frame closes. Whether a command is accepted is decided when its opcode arrives.

Top module: `aai_word_seq`

## Requirements
- R1: Opcode 06h sets the write-enable latch (`wel`) when the mode is inactive. An ADh frame received while `wel` is 0 and the mode is inactive produces no request and leaves `aai_active` at 0.
- R2: In the opening ADh frame, bytes 1 to 3 are address bits 23:16, 15:8 and 7:0, and address bit 0 is forced to 0. Byte 4 is the low word byte (even address) and byte 5 is the high word byte, so `prog_word` = {byte5, byte4}. When the frame closes, `prog_req` pulses for one cycle in the following cycle and `aai_active` goes to 1.
- R3: Each accepted continuation ADh frame carries two data bytes, low byte first. It requests the previous request address plus 2, modulo 2^24, so FFFFFEh is followed by 000000h.
- R4: A continuation ADh frame whose opcode arrives while `busy` is 1 produces no request and does not advance the address.
- R5: An ADh frame that closes before all of its bytes have arrived (5 bytes for the opening frame, 2 for a continuation) produces no request and changes neither the mode nor the address.
- R6: `busy` is 1 in the same cycle as `prog_req` and stays 1 for exactly PROG_CYCLES cycles.
- R7: While the mode is active and `busy` is 0, opcode 04h or 05h ends the mode and clears `wel`. While `busy` is 1, both opcodes leave the mode running. Outside the mode, 04h clears `wel`.
- R8: Opcode 70h enables ready/busy reporting and 80h disables it (disabled after reset). `so_oe` is 1 only when reporting is enabled, the mode is active, `cs_n` is 0 and no opcode has arrived in the current frame. `so_out` is 0 while busy and 1 while ready.
- R9: After reset `wel`, `aai_active`, `busy`, `prog_req` and `so_oe` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip-select level, low inside a frame |
| cmd_valid | input | 1 | Opcode byte complete (one pulse per frame) |
| cmd_op | input | 8 | Opcode value, valid with cmd_valid |
| byte_valid | input | 1 | A later byte of the frame is complete |
| byte_data | input | 8 | Byte value, valid with byte_valid |
| frame_end | input | 1 | Frame closed (chip-select rose) |
| prog_req | output | 1 | One-cycle word program request |
| prog_addr | output | ADDR_W | Even byte address of the request |
| prog_word | output | 16 | Word to program, high byte at the odd address |
| busy | output | 1 | Program engine model busy |
| aai_active | output | 1 | Auto-increment mode is active |
| wel | output | 1 | Write-enable latch |
| so_oe | output | 1 | Serial-out drive enable for ready/busy |
| so_out | output | 1 | Ready/busy level (1 = ready) |

## Verification
Two decisions overlap in time: the busy window started by one request, and the opcode of the next frame. A continuation and a status read are both judged against the busy level at the moment their opcode arrives. The bench opens both frames immediately after a request, while the busy counter is still running. It expects no second request and the mode to stay active, and it shows the address was not advanced by checking that the next accepted continuation lands exactly two bytes on. The ready/busy level is also sampled in an open, opcode-free frame while the counter runs and again once it has drained, so the serial-out indication is compared against the same window.

// File: rtl/aai_pkg.sv
package aai_pkg;

    localparam logic [7:0] OP_AAI    = 8'hAD;
    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_WRDI   = 8'h04;
    localparam logic [7:0] OP_RDSR   = 8'h05;
    localparam logic [7:0] OP_RB_ON  = 8'h70;
    localparam logic [7:0] OP_RB_OFF = 8'h80;

    // Action latched when the opcode arrives, executed when the frame closes
    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_WREN,
        ACT_END,
        ACT_FIRST,
        ACT_NEXT,
        ACT_RB_ON,
        ACT_RB_OFF
    } act_e;

endpackage

// File: rtl/aai_byte_collect.sv
module aai_byte_collect #(
    parameter int NBYTES = 5,
    parameter int CW     = $clog2(NBYTES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                byte_valid,
    input  logic [7:0]          byte_data,
    output logic [CW-1:0]       count,
    output logic [NBYTES*8-1:0] bytes
);

    typedef struct packed {
        logic [CW-1:0]       cnt;
        logic [NBYTES*8-1:0] data;
    } col_t;

    col_t col_d, col_q;

    always_comb begin
        col_d = col_q;
        if (clr) begin
            col_d.cnt = '0;
        end else if (byte_valid && (col_q.cnt < CW'(NBYTES))) begin
            col_d.cnt = col_q.cnt + 1'b1;
            for (int i = 0; i < NBYTES; i++) begin
                if (col_q.cnt == CW'(i)) begin
                    col_d.data[8*i +: 8] = byte_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q <= '0;
        end else begin
            col_q <= col_d;
        end
    end

    assign count = col_q.cnt;
    assign bytes = col_q.data;

endmodule

// File: rtl/aai_busy_model.sv
module aai_busy_model #(
    parameter int CYCLES = 12,
    parameter int CW     = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load) begin
            cnt_d = CW'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/aai_rb_drive.sv
module aai_rb_drive (
    input  logic clk,
    input  logic rst_n,
    input  logic set_en,
    input  logic set_dis,
    input  logic aai_active,
    input  logic cs_n,
    input  logic cmd_seen,
    input  logic busy,
    output logic so_oe,
    output logic so_out
);

    logic en_d, en_q;

    always_comb begin
        en_d = en_q;
        if (set_en) begin
            en_d = 1'b1;
        end else if (set_dis) begin
            en_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= en_d;
        end
    end

    assign so_oe  = en_q & aai_active & ~cs_n & ~cmd_seen;
    assign so_out = ~busy;

endmodule

// File: rtl/aai_word_seq.sv
module aai_word_seq
    import aai_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int PROG_CYCLES = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_op,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              frame_end,
    output logic              prog_req,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [15:0]       prog_word,
    output logic              busy,
    output logic              aai_active,
    output logic              wel,
    output logic              so_oe,
    output logic              so_out
);

    localparam int ABYTES = (ADDR_W + 7) / 8;
    localparam int NBYTES = ABYTES + 2;
    localparam int CW     = $clog2(NBYTES + 1);

    typedef struct packed {
        act_e              act;
        logic              aai;
        logic              wel;
        logic              seen;
        logic [ADDR_W-1:0] addr;
        logic              req;
        logic [ADDR_W-1:0] req_addr;
        logic [15:0]       req_word;
    } seq_t;

    seq_t st_d, st_q;

    logic [CW-1:0]       col_cnt;
    logic [NBYTES*8-1:0] col_bytes;
    logic                eng_busy;
    logic                rb_set_en;
    logic                rb_set_dis;
    logic [ABYTES*8-1:0] start_acc;
    logic [ADDR_W-1:0]   start_addr;
    logic [ADDR_W-1:0]   next_addr;

    aai_byte_collect #(
        .NBYTES (NBYTES),
        .CW     (CW)
    ) u_collect (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (cmd_valid | frame_end),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .count      (col_cnt),
        .bytes      (col_bytes)
    );

    aai_busy_model #(
        .CYCLES (PROG_CYCLES)
    ) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (st_d.req),
        .busy  (eng_busy)
    );

    // Start address: address bytes arrive most significant first
    always_comb begin
        start_acc = '0;
        for (int i = 0; i < ABYTES; i++) begin
            start_acc       = start_acc << 8;
            start_acc[7:0]  = col_bytes[8*i +: 8];
        end
        start_addr    = start_acc[ADDR_W-1:0];
        start_addr[0] = 1'b0;
        next_addr     = st_q.addr + ADDR_W'(2);
    end

    function automatic act_e decode(input logic [7:0] op, input logic in_aai,
                                    input logic latch, input logic eng);
        act_e a;
        a = ACT_NONE;
        case (op)
            OP_WREN:   a = in_aai ? ACT_NONE : ACT_WREN;
            OP_WRDI:   a = (in_aai && eng) ? ACT_NONE : ACT_END;
            OP_RDSR:   a = (in_aai && !eng) ? ACT_END : ACT_NONE;
            OP_AAI: begin
                if (!in_aai) begin
                    a = latch ? ACT_FIRST : ACT_NONE;
                end else begin
                    a = eng ? ACT_NONE : ACT_NEXT;
                end
            end
            OP_RB_ON:  a = ACT_RB_ON;
            OP_RB_OFF: a = ACT_RB_OFF;
            default:   a = ACT_NONE;
        endcase
        return a;
    endfunction

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;

        if (cmd_valid) begin
            st_d.seen = 1'b1;
            st_d.act  = decode(cmd_op, st_q.aai, st_q.wel, eng_busy);
        end

        if (frame_end) begin
            st_d.seen = 1'b0;
            st_d.act  = ACT_NONE;
            case (st_q.act)
                ACT_WREN: st_d.wel = 1'b1;
                ACT_END: begin
                    st_d.aai = 1'b0;
                    st_d.wel = 1'b0;
                end
                ACT_FIRST: begin
                    if (col_cnt >= CW'(NBYTES)) begin
                        st_d.aai      = 1'b1;
                        st_d.addr     = start_addr;
                        st_d.req      = 1'b1;
                        st_d.req_addr = start_addr;
                        st_d.req_word = {col_bytes[8*(ABYTES+1) +: 8],
                                         col_bytes[8*ABYTES +: 8]};
                    end
                end
                ACT_NEXT: begin
                    if (col_cnt >= CW'(2)) begin
                        st_d.addr     = next_addr;
                        st_d.req      = 1'b1;
                        st_d.req_addr = next_addr;
                        st_d.req_word = {col_bytes[15:8], col_bytes[7:0]};
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{act: ACT_NONE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rb_set_en  = frame_end && (st_q.act == ACT_RB_ON);
    assign rb_set_dis = frame_end && (st_q.act == ACT_RB_OFF);

    aai_rb_drive u_rb (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_en     (rb_set_en),
        .set_dis    (rb_set_dis),
        .aai_active (st_q.aai),
        .cs_n       (cs_n),
        .cmd_seen   (st_q.seen | cmd_valid),
        .busy       (eng_busy),
        .so_oe      (so_oe),
        .so_out     (so_out)
    );

    assign prog_req   = st_q.req;
    assign prog_addr  = st_q.req_addr;
    assign prog_word  = st_q.req_word;
    assign busy       = eng_busy;
    assign aai_active = st_q.aai;
    assign wel        = st_q.wel;

endmodule

// File: rtl/aai_word_seq_checker.sv
module aai_word_seq_checker (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic prog_req,
    input logic addr_lsb,
    input logic busy,
    input logic aai_active,
    input logic wel,
    input logic so_oe
);

    // R2: a request lasts one cycle
    a_r2_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |=> !prog_req);

    // R6: the engine model is busy while a request is presented
    a_r6_busy_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> busy);

    // R4: no request follows a cycle in which the engine was busy
    a_r4_req_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> !$past(busy));

    // R2, R3: word requests use even addresses
    a_r3_addr_even: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> !addr_lsb);

    // R1: the mode never runs without the write-enable latch
    a_r1_mode_has_wel: assert property (@(posedge clk) disable iff (!rst_n)
        aai_active |-> wel);

    // R7: leaving the mode leaves the latch cleared
    a_r7_end_clears_wel: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(aai_active) |-> !wel);

    // R8: serial-out is driven only in the mode inside a frame
    a_r8_so_in_mode: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> (aai_active && !cs_n));

endmodule

bind aai_word_seq aai_word_seq_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .prog_req   (prog_req),
    .addr_lsb   (prog_addr[0]),
    .busy       (busy),
    .aai_active (aai_active),
    .wel        (wel),
    .so_oe      (so_oe)
);

// File: tb/aai_word_seq_bench.sv
module aai_word_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int PC         = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_op = 8'h00;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic        frame_end = 1'b0;
    logic        prog_req;
    logic [23:0] prog_addr;
    logic [15:0] prog_word;
    logic        busy;
    logic        aai_active;
    logic        wel;
    logic        so_oe;
    logic        so_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [23:0] addr;
        logic [15:0] word;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    aai_word_seq #(
        .ADDR_W      (24),
        .PROG_CYCLES (PC)
    ) u_aai_word_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .frame_end  (frame_end),
        .prog_req   (prog_req),
        .prog_addr  (prog_addr),
        .prog_word  (prog_word),
        .busy       (busy),
        .aai_active (aai_active),
        .wel        (wel),
        .so_oe      (so_oe),
        .so_out     (so_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [23:0] a, input logic [15:0] w, input string tag);
        exp_t e;
        e.addr = a;
        e.word = w;
        e.tag  = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: every request must match the oldest expected item
    always @(negedge clk) begin
        if (rst_n && prog_req) begin
            if (exp_q.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R1/R4/R5 unexpected request actual=%h/%h expected=none",
                         prog_addr, prog_word);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk({e.tag, " address"}, {8'h0, prog_addr}, {8'h0, e.addr});
                chk({e.tag, " word"}, {16'h0, prog_word}, {16'h0, e.word});
            end
        end
    end

    task automatic frame_start();
        cs_n = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_cmd(input logic [7:0] op);
        cmd_valid = 1'b1;
        cmd_op    = op;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        byte_valid = 1'b1;
        byte_data  = b;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic frame_stop();
        frame_end = 1'b1;
        cs_n      = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
    endtask

    task automatic simple(input logic [7:0] op);
        frame_start();
        send_cmd(op);
        frame_stop();
    endtask

    task automatic aai_first(input logic [23:0] a, input logic [7:0] lo, input logic [7:0] hi);
        frame_start();
        send_cmd(8'hAD);
        send_byte(a[23:16]);
        send_byte(a[15:8]);
        send_byte(a[7:0]);
        send_byte(lo);
        send_byte(hi);
        frame_stop();
    endtask

    task automatic aai_next(input logic [7:0] lo, input logic [7:0] hi);
        frame_start();
        send_cmd(8'hAD);
        send_byte(lo);
        send_byte(hi);
        frame_stop();
    endtask

    task automatic wait_ready();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state
        chk("R9 wel", {31'h0, wel}, 32'h0);
        chk("R9 aai_active", {31'h0, aai_active}, 32'h0);
        chk("R9 busy", {31'h0, busy}, 32'h0);
        chk("R9 prog_req", {31'h0, prog_req}, 32'h0);
        chk("R9 so_oe", {31'h0, so_oe}, 32'h0);

        // R1: opening frame without write enable is ignored
        aai_first(24'h010203, 8'h11, 8'h22);
        chk("R1 mode stays off without latch", {31'h0, aai_active}, 32'h0);
        simple(8'h06);
        chk("R1 latch set by 06h", {31'h0, wel}, 32'h1);

        // R5: short opening frame
        frame_start();
        send_cmd(8'hAD);
        send_byte(8'h12);
        send_byte(8'h34);
        send_byte(8'h56);
        frame_stop();
        chk("R5 short opening frame leaves mode off", {31'h0, aai_active}, 32'h0);
        chk("R5 latch kept", {31'h0, wel}, 32'h1);

        // R2: opening frame, odd address forced even
        push(24'h123456, 16'hB2A1, "R2");
        aai_first(24'h123457, 8'hA1, 8'hB2);
        chk("R2 mode active", {31'h0, aai_active}, 32'h1);
        chk("R6 busy with request", {31'h0, busy}, 32'h1);

        // R4: continuation while busy is ignored; R7: status read while busy
        aai_next(8'hEE, 8'hFF);
        simple(8'h05);
        chk("R7 status read while busy keeps mode", {31'h0, aai_active}, 32'h1);
        wait_ready();

        // R8: ready/busy reporting
        simple(8'h70);
        frame_start();
        chk("R8 drive in empty frame", {31'h0, so_oe}, 32'h1);
        chk("R8 ready level", {31'h0, so_out}, 32'h1);
        push(24'h123458, 16'h4433, "R3 R4");
        send_cmd(8'hAD);
        chk("R8 no drive after opcode", {31'h0, so_oe}, 32'h0);
        send_byte(8'h33);
        send_byte(8'h44);
        frame_stop();
        frame_start();
        chk("R8 drive while busy", {31'h0, so_oe}, 32'h1);
        chk("R8 busy level", {31'h0, so_out}, 32'h0);
        frame_stop();
        wait_ready();

        // R6: busy window length
        push(24'h12345A, 16'h6655, "R3");
        aai_next(8'h55, 8'h66);
        chk("R6 busy at request", {31'h0, busy}, 32'h1);
        repeat (PC - 1) @(negedge clk);
        chk("R6 busy on last cycle", {31'h0, busy}, 32'h1);
        @(negedge clk);
        chk("R6 ready after window", {31'h0, busy}, 32'h0);

        // R5: short continuation, then address must not have moved
        frame_start();
        send_cmd(8'hAD);
        send_byte(8'h77);
        frame_stop();
        chk("R5 mode kept after short continuation", {31'h0, aai_active}, 32'h1);
        push(24'h12345C, 16'h8877, "R5 R3");
        aai_next(8'h77, 8'h88);
        wait_ready();

        // R8: disable reporting
        simple(8'h80);
        frame_start();
        chk("R8 no drive after 80h", {31'h0, so_oe}, 32'h0);
        frame_stop();

        // R7: write-disable ends the mode
        simple(8'h04);
        chk("R7 04h ends mode", {31'h0, aai_active}, 32'h0);
        chk("R7 04h clears latch", {31'h0, wel}, 32'h0);
        aai_first(24'h000100, 8'h01, 8'h02);
        chk("R1 no restart without latch", {31'h0, aai_active}, 32'h0);

        // R3: address wraps at the top
        simple(8'h06);
        push(24'hFFFFFE, 16'hBBAA, "R2 top");
        aai_first(24'hFFFFFF, 8'hAA, 8'hBB);
        wait_ready();
        push(24'h000000, 16'hDDCC, "R3 wrap");
        aai_next(8'hCC, 8'hDD);
        wait_ready();

        // R7: status read while idle ends the mode
        simple(8'h05);
        chk("R7 05h ends mode", {31'h0, aai_active}, 32'h0);
        chk("R7 05h clears latch", {31'h0, wel}, 32'h0);

        repeat (3) @(negedge clk);
        chk("R2 R3 all expected requests seen", exp_q.size(), 32'h0);
        report();
    end

endmodule